// File: doc/BRIEF.md
# Reserved-Entry Queue Admission Controller

This block guards the input of a shared memory request queue. It keeps the top slots of the queue free for privileged agents, such as an I/O bridge. It counts how many entries the queue holds from enqueue and dequeue pulses. It compares that count against two programmable 4-bit levels:

- **Engage level.** When the count reaches this level, the block stalls every non-privileged requester.
- **Release level.** Once stalled, non-privileged requesters stay stalled until the count drains down to this level.

The gap between the two levels gives hysteresis, so the stall does not chatter when occupancy hovers near one value. Privileged requesters are never stalled by this mechanism. The only thing that turns a privileged requester away is a completely full queue.

Each agent presents a request valid signal and a privileged flag. The block answers each agent with a ready signal. A request transfers when valid and ready are high in the same cycle. Ready is a function of the current state and of the agent's own valid and privileged inputs; it never depends on another agent's signals.

The queue storage and the choice among several ready non-privileged requesters lie outside the block. The enqueue and dequeue pulses come from that surrounding logic. The two levels are captured from input pins on a write strobe.

Top module: `rq_admission_ctrl`

## Requirements
- R1: After reset the occupancy is 0, the stall is inactive, and both the engage level and the release level hold 0xA.
- R2: On each clock edge the occupancy rises by one on an enqueue alone and falls by one on a dequeue alone. It stays unchanged when both pulses or neither are present.
- R3: An enqueue alone while the occupancy equals DEPTH leaves it at DEPTH. A dequeue alone while the occupancy is 0 leaves it at 0.
- R4: While `thr_wr` is high at a clock edge, `thr_engage` and `thr_release` are captured and take effect from the next edge on. While `thr_wr` is low, the levels are unchanged.
- R5: If the registered occupancy is greater than or equal to the engage level at a clock edge, the stall is active after that edge.
- R6: If the registered occupancy is below the engage level and less than or equal to the release level, the stall is inactive after the edge.
- R7: If the registered occupancy is below the engage level and above the release level, the stall keeps its previous value.
- R8: When the release level is above the engage level, the stall equals the comparison "occupancy >= engage level" from the previous edge.
- R9: A privileged agent whose valid is high sees ready high whenever the occupancy is below DEPTH, whatever the stall state.
- R10: While the occupancy equals DEPTH, every ready output is low, including those of privileged agents.
- R11: Ready is low for any agent whose valid is low. A non-privileged agent with valid high sees ready high exactly when the stall is inactive and the occupancy is below DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_AGENTS | Per-agent request valid |
| req_priv | input | N_AGENTS | Per-agent privileged flag (1 = exempt from stall) |
| enq | input | 1 | One entry enters the queue this cycle |
| deq | input | 1 | One entry leaves the queue this cycle |
| thr_wr | input | 1 | Capture strobe for the two levels |
| thr_engage | input | 4 | Occupancy at which the stall engages |
| thr_release | input | 4 | Occupancy at or below which the stall releases |
| req_ready | output | N_AGENTS | Per-agent ready |
| occupancy | output | $clog2(DEPTH+1) | Current queue occupancy |

## Verification
The bench builds the block with four agents and a depth of 16. Because 16 is one above the largest 4-bit level, an engage level of 15 can be programmed and the queue can still reach full. This makes the stall-then-full sequence and the saturation at full reachable, together with the empty-side saturation. With four agents, privileged and non-privileged requesters appear side by side in the same cycle, so the exemption is seen against a stalled neighbour. The random phases reprogram both levels at random, including a release level above the engage level, so the hysteresis band, a zero-width band and the inverted case are all visited.

// File: rtl/rq_adm_pkg.sv
package rq_adm_pkg;
  typedef logic [3:0] level_t;
  localparam level_t LEVEL_RESET = 4'hA;
endpackage

// File: rtl/rq_occ_counter.sv
module rq_occ_counter #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq,
  input  logic          deq,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] MAX_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt_nxt;

  assign full  = (cnt == MAX_CNT);
  assign empty = (cnt == '0);

  always_comb begin
    cnt_nxt = cnt;
    unique case ({enq, deq})
      2'b10:   if (!full)  cnt_nxt = cnt + 1'b1;
      2'b01:   if (!empty) cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R2
  occ_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq && !deq && !full) |=> (cnt == $past(cnt) + 1'b1));
  // R2
  occ_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq && !enq && !empty) |=> (cnt == $past(cnt) - 1'b1));
  // R2
  occ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq == deq) |=> $stable(cnt));
  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= MAX_CNT);
endmodule

// File: rtl/rq_level_regs.sv
module rq_level_regs
  import rq_adm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr,
  input  level_t engage_in,
  input  level_t release_in,
  output level_t engage_q,
  output level_t release_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      engage_q  <= LEVEL_RESET;
      release_q <= LEVEL_RESET;
    end else if (wr) begin
      engage_q  <= engage_in;
      release_q <= release_in;
    end
  end

  // R4
  lvl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (engage_q == $past(engage_in)) && (release_q == $past(release_in)));
  // R4
  lvl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(engage_q) && $stable(release_q));
endmodule

// File: rtl/rq_stall_state.sv
module rq_stall_state
  import rq_adm_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  level_t        engage,
  input  level_t        release_lvl,
  output logic          stalled
);
  logic at_engage;
  logic at_release;

  assign at_engage  = (cnt >= CW'(engage));
  assign at_release = (cnt <= CW'(release_lvl));

  always_ff @(posedge clk) begin
    if (!rst_n)          stalled <= 1'b0;
    else if (at_engage)  stalled <= 1'b1;
    else if (at_release) stalled <= 1'b0;
  end

  // R5
  stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= CW'(engage)) |=> stalled);
  // R6
  stall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt < CW'(engage)) && (cnt <= CW'(release_lvl))) |=> !stalled);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt < CW'(engage)) && (cnt > CW'(release_lvl))) |=> $stable(stalled));
  // R8
  stall_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (release_lvl > engage) |=> (stalled == ($past(cnt) >= CW'($past(engage)))));
endmodule

// File: rtl/rq_ready_gate.sv
module rq_ready_gate #(
  parameter int N_AGENTS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] valid,
  input  logic [N_AGENTS-1:0] priv,
  input  logic                stalled,
  input  logic                full,
  output logic [N_AGENTS-1:0] ready
);
  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    assign ready[g] = valid[g] & ~full & (priv[g] | ~stalled);

    // R9
    priv_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[g] && priv[g] && !full) |-> ready[g]);
    // R11
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid[g] |-> !ready[g]);
  end

  // R10
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (ready == '0));
  // R11
  stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> ((ready & ~priv) == '0));
endmodule

// File: rtl/rq_admission_ctrl.sv
module rq_admission_ctrl
  import rq_adm_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int DEPTH    = 16,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] req_valid,
  input  logic [N_AGENTS-1:0] req_priv,
  input  logic                enq,
  input  logic                deq,
  input  logic                thr_wr,
  input  logic [3:0]          thr_engage,
  input  logic [3:0]          thr_release,
  output logic [N_AGENTS-1:0] req_ready,
  output logic [CW-1:0]       occupancy
);
  logic   full;
  logic   empty;
  logic   stalled;
  level_t engage_q;
  level_t release_q;

  rq_occ_counter #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .enq   (enq),
    .deq   (deq),
    .cnt   (occupancy),
    .full  (full),
    .empty (empty)
  );

  rq_level_regs u_lvl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (thr_wr),
    .engage_in  (thr_engage),
    .release_in (thr_release),
    .engage_q   (engage_q),
    .release_q  (release_q)
  );

  rq_stall_state #(.CW(CW)) u_stall (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt         (occupancy),
    .engage      (engage_q),
    .release_lvl (release_q),
    .stalled     (stalled)
  );

  rq_ready_gate #(.N_AGENTS(N_AGENTS)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (req_valid),
    .priv    (req_priv),
    .stalled (stalled),
    .full    (full),
    .ready   (req_ready)
  );

  // R1
  rst_state_chk: assert property (@(posedge clk)
    !rst_n |=> (occupancy == '0) && !stalled
               && (engage_q == LEVEL_RESET) && (release_q == LEVEL_RESET));
  // R3
  empty_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && deq && !enq) |=> (occupancy == '0));
endmodule

// File: tb/rq_admission_ctrl_tb.sv
`timescale 1ns/1ps
module rq_admission_ctrl_tb;
  localparam int N  = 4;
  localparam int D  = 16;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_valid = '0;
  logic [N-1:0]  req_priv = '0;
  logic          enq = 1'b0, deq = 1'b0, thr_wr = 1'b0;
  logic [3:0]    thr_engage = 4'h0, thr_release = 4'h0;
  logic [N-1:0]  req_ready;
  logic [CW-1:0] occupancy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  string cur_tag = "R1";

  // reference model state
  int m_cnt = 0;
  bit m_stall = 1'b0;
  int m_eng = 10;
  int m_rel = 10;

  always #10 clk = ~clk;

  rq_admission_ctrl #(.N_AGENTS(N), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
    .enq(enq), .deq(deq), .thr_wr(thr_wr), .thr_engage(thr_engage),
    .thr_release(thr_release), .req_ready(req_ready), .occupancy(occupancy)
  );

  function automatic logic [N-1:0] exp_ready(logic [N-1:0] v, logic [N-1:0] p,
                                             int c, bit s);
    exp_ready = v & ~{N{c == D}} & (p | ~{N{s}});
  endfunction

  function automatic int exp_cnt(int c, bit e, bit d);
    exp_cnt = c;
    if (e && !d && c < D) exp_cnt = c + 1;
    if (d && !e && c > 0) exp_cnt = c - 1;
  endfunction

  function automatic bit exp_stall(int c, bit s, int eng, int rel);
    if (c >= eng)      exp_stall = 1'b1;
    else if (c <= rel) exp_stall = 1'b0;
    else               exp_stall = s;
  endfunction

  task automatic check_outs();
    logic [N-1:0] er;
    er = exp_ready(req_valid, req_priv, m_cnt, m_stall);
    n_chk++;
    if (int'(occupancy) != m_cnt) begin
      n_bad++;
      $display("FAIL %s occupancy: actual %0d expected %0d", cur_tag, occupancy, m_cnt);
    end
    n_chk++;
    if (req_ready !== er) begin
      n_bad++;
      $display("FAIL %s ready: actual %b expected %b (valid %b priv %b)",
               cur_tag, req_ready, er, req_valid, req_priv);
    end
  endtask

  task automatic step(logic [N-1:0] v, logic [N-1:0] p, bit e, bit d,
                      bit w, logic [3:0] eng, logic [3:0] rel);
    int  nc;
    bit  ns;
    @(negedge clk);
    req_valid = v; req_priv = p; enq = e; deq = d;
    thr_wr = w; thr_engage = eng; thr_release = rel;
    #1;
    check_outs();
    nc = exp_cnt(m_cnt, e, d);
    ns = exp_stall(m_cnt, m_stall, m_eng, m_rel);
    @(posedge clk);
    m_cnt = nc;
    m_stall = ns;
    if (w) begin m_eng = int'(eng); m_rel = int'(rel); end
  endtask

  task automatic set_levels(int eng, int rel);
    step(4'b1111, 4'b0001, 1'b0, 1'b0, 1'b1, 4'(eng), 4'(rel));
  endtask

  task automatic push(int k);
    for (int i = 0; i < k; i++) step(4'b1111, 4'b0011, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0);
  endtask

  task automatic pop(int k);
    for (int i = 0; i < k; i++) step(4'b1111, 4'b0011, 1'b0, 1'b1, 1'b0, 4'h0, 4'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, default levels of 0xA
    cur_tag = "R1";
    step(4'b1111, 4'b0000, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
    push(9);
    step(4'b1111, 4'b0000, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0); // count reaches 10
    step(4'b1111, 4'b0000, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0); // stall engages with default level
    pop(10);

    // R11: no valid -> no ready
    cur_tag = "R11";
    step(4'b0000, 4'b1111, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
    step(4'b0101, 4'b0000, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);

    // R4 R5 R6 R7: band of 6..12
    cur_tag = "R4";
    set_levels(12, 6);
    cur_tag = "R5";
    push(13);
    cur_tag = "R7";
    pop(4);
    step(4'b1111, 4'b1010, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
    cur_tag = "R9";
    step(4'b1111, 4'b0101, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0);
    cur_tag = "R6";
    pop(5);

    // R10 R3: engage 15, fill to full and beyond
    cur_tag = "R10";
    set_levels(15, 3);
    push(D);
    cur_tag = "R3";
    push(3);
    step(4'b1111, 4'b1111, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0);
    cur_tag = "R2";
    step(4'b1111, 4'b0001, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0);
    pop(D);
    cur_tag = "R3";
    pop(3);
    step(4'b1111, 4'b0000, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0);

    // R8: release level above engage level
    cur_tag = "R8";
    set_levels(4, 12);
    push(8);
    pop(6);
    push(2);

    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      int bias;
      bias = int'($urandom_range(0, 2));
      cur_tag = (ph % 2 == 0) ? "R7" : "R2";
      for (int c = 0; c < 60; c++) begin
        logic [N-1:0] v, p;
        bit e, d, w;
        int r;
        v = N'($urandom);
        p = N'($urandom);
        r = int'($urandom_range(0, 9));
        e = (bias == 0) ? (r < 7) : (bias == 1) ? (r < 3) : (r < 5);
        d = (bias == 0) ? (r > 7) : (bias == 1) ? (r > 3) : (r > 4);
        w = ($urandom_range(0, 49) == 0);
        step(v, p, e, d, w, 4'($urandom), 4'($urandom));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule